// File: doc/BRIEF.md
# Flash Toggle-Bit Completion Poller

This block decides when an embedded erase or program operation inside a flash device has finished. A single-cycle start request carries the status address to watch and a time budget in milliseconds. The block then polls that address over a one-outstanding read channel. Each polling round is a throw-away read followed by a pair of compared reads. The operation has finished when the toggle bit (status bit 6) holds the same value in both reads of the pair. If the toggle bit still moves but the device has raised its own time-limit flag (status bit 5) in the first read of the pair, one confirming pair of reads settles the outcome. If neither case applies, the block waits for the next millisecond tick, counts it and starts a new round.

The outcome is a one-cycle `done` pulse with an `ok` flag and the number of milliseconds counted. Both stay valid until the next start. Typical budgets are 500 ms for a sector erase and 20000 ms for a whole-chip erase, and both fit the default 16-bit limit.

The read request channel uses valid/ready. `rd_valid` rises with an address and stays high with that address unchanged until the cycle in which `rd_ready` is high, and that cycle completes the request. The block never has more than one read outstanding. The response side has no back-pressure. The block takes `rd_rsp_valid` only while it waits for an accepted read, and the responder must return exactly one response no earlier than one cycle after acceptance.

Top module: `flash_toggle_poller`

## Requirements
- R1: After reset `busy`, `done`, `ok` and `rd_valid` are all low.
- R2: Every polling round starts with one read whose data is discarded, so its bit 6 and bit 5 never change the result. Every read a poll issues goes to the address given at start.
- R3: When bit 6 of the two compared reads after the discarded read is equal, the poll ends with `ok` high.
- R4: When bit 6 differs and bit 5 is set in the first read of the pair, exactly one further pair of reads is made. Equal bit 6 in that pair ends the poll with `ok` high.
- R5: When bit 6 still differs in that confirming pair, the poll ends with `ok` low.
- R6: When bit 6 differs and bit 5 of the first read is clear, the block waits for the next `ms_tick`, adds one to its millisecond count and starts a new round.
- R7: The poll fails once the millisecond count exceeds the start limit. A limit of L therefore fails with a count of L+1, and a successful poll always reports a count of at most L.
- R8: A response with `rd_rsp_err` high ends the poll at once with `ok` low. No further read is issued.
- R9: `done` is high for exactly one cycle per poll. `elapsed_ms` then holds the millisecond count reached.
- R10: A start request while `busy` is high is ignored, and the running poll keeps its address, limit and result.
- R11: `rd_valid` stays high with a stable `rd_addr` until accepted. A new read is issued only after the response to the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start pulse, taken only while idle |
| start_addr | input | ADDR_W | Status address to poll |
| start_limit | input | LIMIT_W | Time budget in milliseconds |
| ms_tick | input | 1 | One-cycle pulse once per millisecond |
| rd_valid | output | 1 | Read request valid |
| rd_ready | input | 1 | Read request accepted when high with `rd_valid` |
| rd_addr | output | ADDR_W | Read request address |
| rd_rsp_valid | input | 1 | Read response valid |
| rd_rsp_data | input | STATUS_W | Read response status word |
| rd_rsp_err | input | 1 | Read response error flag |
| busy | output | 1 | A poll is running |
| done | output | 1 | One-cycle completion pulse |
| ok | output | 1 | Result of the last poll: 1 is success |
| elapsed_ms | output | LIMIT_W+1 | Millisecond count at the last completion |

## Verification
The bench builds the block with `LIMIT_W` set to 4 and `ADDR_W` set to 16. A narrow limit lets the full budget range be run to the end, including the largest limit of 15. That case drives the count to 16, which needs the extra count bit above the limit width. The tick period is short, so many timeout rounds fit in each run. The bench varies read acceptance and response latency at random. It predicts the outcome, the count and the number of reads from the scripted status words alone.

// File: rtl/ftp_pkg.sv
package ftp_pkg;

  // status word bit positions decoded by the poller
  localparam int TOGGLE_BIT = 6;
  localparam int TLIM_BIT   = 5;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_DISCARD = 3'd1,
    ST_PAIR_A  = 3'd2,
    ST_PAIR_B  = 3'd3,
    ST_CONF_A  = 3'd4,
    ST_CONF_B  = 3'd5,
    ST_WAIT_MS = 3'd6
  } poll_state_t;

endpackage

// File: rtl/ftp_read_port.sv
module ftp_read_port #(
  parameter int ADDR_W   = 32,
  parameter int STATUS_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                go,
  input  logic [ADDR_W-1:0]   go_addr,
  output logic                rd_valid,
  input  logic                rd_ready,
  output logic [ADDR_W-1:0]   rd_addr,
  input  logic                rsp_valid,
  input  logic [STATUS_W-1:0] rsp_data,
  input  logic                rsp_err,
  output logic                fire,
  output logic [STATUS_W-1:0] fire_data,
  output logic                fire_err
);

  logic              req_q;
  logic              wait_q;
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= 1'b0;
      wait_q <= 1'b0;
      addr_q <= '0;
    end else begin
      if (go) begin
        req_q  <= 1'b1;
        addr_q <= go_addr;
      end else if (req_q && rd_ready) begin
        req_q <= 1'b0;
      end
      if (req_q && rd_ready) begin
        wait_q <= 1'b1;
      end else if (wait_q && rsp_valid) begin
        wait_q <= 1'b0;
      end
    end
  end

  assign rd_valid  = req_q;
  assign rd_addr   = addr_q;
  assign fire      = wait_q && rsp_valid;
  assign fire_data = rsp_data;
  assign fire_err  = rsp_err;

  // R11: a request holds until accepted
  p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_addr));

  // R11: a new read only once the previous one has been answered
  p_one_outstanding_r11: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> !req_q && (!wait_q || rsp_valid));

endmodule

// File: rtl/ftp_toggle_judge.sv
module ftp_toggle_judge (
  input  logic clk,
  input  logic rst_n,
  input  logic capture,
  input  logic cur_toggle,
  input  logic cur_tlim,
  output logic toggle_same,
  output logic first_tlim
);

  logic first_toggle_q;
  logic first_tlim_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      first_toggle_q <= 1'b0;
      first_tlim_q   <= 1'b0;
    end else if (capture) begin
      first_toggle_q <= cur_toggle;
      first_tlim_q   <= cur_tlim;
    end
  end

  assign toggle_same = (first_toggle_q == cur_toggle);
  assign first_tlim  = first_tlim_q;

endmodule

// File: rtl/ftp_ms_window.sv
module ftp_ms_window #(
  parameter int LIMIT_W = 16,
  localparam int CNT_W  = LIMIT_W + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear,
  input  logic [LIMIT_W-1:0] limit_in,
  input  logic               bump,
  output logic [CNT_W-1:0]   count,
  output logic [CNT_W-1:0]   count_inc,
  output logic               exceed_on_bump,
  output logic [LIMIT_W-1:0] limit
);

  logic [CNT_W-1:0]   count_q;
  logic [LIMIT_W-1:0] limit_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      limit_q <= '0;
    end else if (clear) begin
      count_q <= '0;
      limit_q <= limit_in;
    end else if (bump) begin
      count_q <= count_inc;
    end
  end

  assign count_inc      = count_q + CNT_W'(1);
  assign exceed_on_bump = count_inc > {1'b0, limit_q};
  assign count          = count_q;
  assign limit          = limit_q;

  // R7: the count never runs more than one past the limit
  p_count_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= {1'b0, limit_q} + CNT_W'(1));

endmodule

// File: rtl/flash_toggle_poller.sv
module flash_toggle_poller
  import ftp_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int LIMIT_W  = 16,
  parameter int STATUS_W = 16,
  localparam int CNT_W   = LIMIT_W + 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [ADDR_W-1:0]   start_addr,
  input  logic [LIMIT_W-1:0]  start_limit,
  input  logic                ms_tick,
  output logic                rd_valid,
  input  logic                rd_ready,
  output logic [ADDR_W-1:0]   rd_addr,
  input  logic                rd_rsp_valid,
  input  logic [STATUS_W-1:0] rd_rsp_data,
  input  logic                rd_rsp_err,
  output logic                busy,
  output logic                done,
  output logic                ok,
  output logic [CNT_W-1:0]    elapsed_ms
);

  poll_state_t         state_q, state_d;
  logic [ADDR_W-1:0]   addr_q;
  logic                done_q, ok_q;
  logic [CNT_W-1:0]    elapsed_q;

  logic                go, capture, bump, clear;
  logic                fin, fin_ok;
  logic [ADDR_W-1:0]   go_addr;
  logic                fire, fire_err;
  logic [STATUS_W-1:0] fire_data;
  logic                toggle_same, first_tlim, exceed_on_bump;
  logic [CNT_W-1:0]    cnt, cnt_inc;
  logic [LIMIT_W-1:0]  limit_q;

  ftp_read_port #(.ADDR_W(ADDR_W), .STATUS_W(STATUS_W)) u_port (
    .clk       (clk),
    .rst_n     (rst_n),
    .go        (go),
    .go_addr   (go_addr),
    .rd_valid  (rd_valid),
    .rd_ready  (rd_ready),
    .rd_addr   (rd_addr),
    .rsp_valid (rd_rsp_valid),
    .rsp_data  (rd_rsp_data),
    .rsp_err   (rd_rsp_err),
    .fire      (fire),
    .fire_data (fire_data),
    .fire_err  (fire_err)
  );

  ftp_toggle_judge u_judge (
    .clk         (clk),
    .rst_n       (rst_n),
    .capture     (capture),
    .cur_toggle  (fire_data[TOGGLE_BIT]),
    .cur_tlim    (fire_data[TLIM_BIT]),
    .toggle_same (toggle_same),
    .first_tlim  (first_tlim)
  );

  ftp_ms_window #(.LIMIT_W(LIMIT_W)) u_window (
    .clk            (clk),
    .rst_n          (rst_n),
    .clear          (clear),
    .limit_in       (start_limit),
    .bump           (bump),
    .count          (cnt),
    .count_inc      (cnt_inc),
    .exceed_on_bump (exceed_on_bump),
    .limit          (limit_q)
  );

  // only the two decoded status bits matter to the poller
  logic unused_status;
  assign unused_status = ^fire_data;

  always_comb begin
    state_d = state_q;
    go      = 1'b0;
    go_addr = addr_q;
    capture = 1'b0;
    bump    = 1'b0;
    clear   = 1'b0;
    fin     = 1'b0;
    fin_ok  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d = ST_DISCARD;
          go      = 1'b1;
          go_addr = start_addr;
          clear   = 1'b1;
        end
      end
      ST_DISCARD: begin
        if (fire) begin
          if (fire_err) fin = 1'b1;
          else begin
            state_d = ST_PAIR_A;
            go      = 1'b1;
          end
        end
      end
      ST_PAIR_A, ST_CONF_A: begin
        if (fire) begin
          if (fire_err) fin = 1'b1;
          else begin
            capture = 1'b1;
            go      = 1'b1;
            state_d = (state_q == ST_PAIR_A) ? ST_PAIR_B : ST_CONF_B;
          end
        end
      end
      ST_PAIR_B: begin
        if (fire) begin
          if (fire_err) fin = 1'b1;
          else if (toggle_same) begin
            fin    = 1'b1;
            fin_ok = 1'b1;
          end else if (first_tlim) begin
            state_d = ST_CONF_A;
            go      = 1'b1;
          end else begin
            state_d = ST_WAIT_MS;
          end
        end
      end
      ST_CONF_B: begin
        if (fire) begin
          fin    = 1'b1;
          fin_ok = !fire_err && toggle_same;
        end
      end
      ST_WAIT_MS: begin
        if (ms_tick) begin
          bump = 1'b1;
          if (exceed_on_bump) fin = 1'b1;
          else begin
            state_d = ST_DISCARD;
            go      = 1'b1;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
    if (fin) state_d = ST_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      addr_q    <= '0;
      done_q    <= 1'b0;
      ok_q      <= 1'b0;
      elapsed_q <= '0;
    end else begin
      state_q <= state_d;
      done_q  <= fin;
      if (clear) addr_q <= start_addr;
      if (fin) begin
        ok_q      <= fin_ok;
        elapsed_q <= bump ? cnt_inc : cnt;
      end
    end
  end

  assign busy       = (state_q != ST_IDLE);
  assign done       = done_q;
  assign ok         = ok_q;
  assign elapsed_ms = elapsed_q;

  // R2: every read of a poll targets the start address
  p_addr_fixed_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> rd_addr == addr_q);

  // R8: an error response ends the poll with a failure
  p_err_fails_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fire && fire_err |=> done && !ok);

  // R9: done is a single-cycle pulse
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7: success is only reported within the budget
  p_ok_in_budget_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done && ok |-> elapsed_ms <= {1'b0, limit_q});

  // R4: the confirming pair follows only a compared pair
  p_confirm_after_pair_r4: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == ST_PAIR_B && state_d == ST_CONF_A |-> !toggle_same && first_tlim);

  // R10: a running poll keeps its address whatever arrives on start
  p_start_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start |=> $stable(addr_q));

endmodule

// File: tb/flash_toggle_poller_bench.sv
module flash_toggle_poller_bench;

  localparam int AW = 16;
  localparam int LW = 4;
  localparam int CW = LW + 1;
  localparam int TICK_P = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [AW-1:0] start_addr = '0;
  logic [LW-1:0] start_limit = '0;
  logic          ms_tick = 1'b0;
  logic          rd_valid;
  logic          rd_ready = 1'b0;
  logic [AW-1:0] rd_addr;
  logic          rd_rsp_valid = 1'b0;
  logic [15:0]   rd_rsp_data = '0;
  logic          rd_rsp_err = 1'b0;
  logic          busy, done, ok;
  logic [CW-1:0] elapsed_ms;

  always #10 clk = ~clk;

  flash_toggle_poller #(.ADDR_W(AW), .LIMIT_W(LW), .STATUS_W(16)) u_flash_toggle_poller (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .start_limit(start_limit), .ms_tick(ms_tick), .rd_valid(rd_valid),
    .rd_ready(rd_ready), .rd_addr(rd_addr), .rd_rsp_valid(rd_rsp_valid),
    .rd_rsp_data(rd_rsp_data), .rd_rsp_err(rd_rsp_err), .busy(busy),
    .done(done), .ok(ok), .elapsed_ms(elapsed_ms)
  );

  int n_checks = 0;
  int n_fail = 0;
  int cycles = 0;

  // device model state
  logic [15:0]   script [64];
  int            base = 0;
  int            err_rel = -1;
  logic [AW-1:0] exp_addr = '0;
  int            n_reads = 0;
  int            addr_bad = 0;
  int            cur = 0;
  int            lat = 0;
  int            tick_div = 0;

  always @(posedge clk) begin
    tick_div <= (tick_div == TICK_P - 1) ? 0 : tick_div + 1;
    ms_tick  <= (tick_div == TICK_P - 1);
  end

  always @(posedge clk) begin
    rd_rsp_valid <= 1'b0;
    if (lat != 0) begin
      lat <= lat - 1;
      if (lat == 1) begin
        rd_rsp_valid <= 1'b1;
        rd_rsp_data  <= script[(cur - base) % 64];
        rd_rsp_err   <= ((cur - base) == err_rel);
      end
    end else if (rd_valid && rd_ready) begin
      cur     <= n_reads;
      n_reads <= n_reads + 1;
      if (rd_addr != exp_addr) addr_bad <= addr_bad + 1;
      lat <= 1 + int'($urandom % 3);
    end
    rd_ready <= ($urandom % 4) != 0;
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 190000) begin
      $display("FAIL watchdog: run did not finish (actual hung, expected finished)");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks + 1, n_fail + 1);
      $finish;
    end
  end

  task automatic check(input bit good, input string tag, input int act, input int exp_v);
    n_checks++;
    if (!good) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp_v);
    end
  endtask

  // outcome predicted from the scripted status words alone
  function automatic void predict(input int lim, input int erri, output bit p_ok,
                                  output int p_ms, output int p_reads, output string tag);
    int idx = 0;
    int ms = 0;
    logic [15:0] a, b, c, d;
    p_ok = 1'b0;
    p_ms = 0;
    p_reads = 0;
    tag = "R3";
    for (int round = 0; round < 40; round++) begin
      if (idx == erri) begin p_reads = idx + 1; p_ms = ms; tag = "R8"; return; end
      idx++;
      if (idx == erri) begin p_reads = idx + 1; p_ms = ms; tag = "R8"; return; end
      a = script[idx]; idx++;
      if (idx == erri) begin p_reads = idx + 1; p_ms = ms; tag = "R8"; return; end
      b = script[idx]; idx++;
      if (a[6] == b[6]) begin p_ok = 1'b1; p_reads = idx; p_ms = ms; tag = "R3"; return; end
      if (a[5]) begin
        if (idx == erri) begin p_reads = idx + 1; p_ms = ms; tag = "R8"; return; end
        c = script[idx]; idx++;
        if (idx == erri) begin p_reads = idx + 1; p_ms = ms; tag = "R8"; return; end
        d = script[idx]; idx++;
        p_ok = (c[6] == d[6]);
        p_reads = idx; p_ms = ms;
        tag = p_ok ? "R4" : "R5";
        return;
      end
      ms++;
      if (ms > lim) begin p_reads = idx; p_ms = ms; tag = "R7"; return; end
    end
  endfunction

  task automatic fill_toggle();
    for (int i = 0; i < 64; i++) script[i] = (i % 2 != 0) ? 16'h0040 : 16'h0000;
  endtask

  task automatic run_trial(input int lim, input int erri, input logic [AW-1:0] addr,
                           input bit poke);
    bit    p_ok;
    int    p_ms, p_reads, wd, bad0;
    string tag;
    predict(lim, erri, p_ok, p_ms, p_reads, tag);
    @(negedge clk);
    base = n_reads;
    err_rel = erri;
    exp_addr = addr;
    bad0 = addr_bad;
    start = 1'b1; start_addr = addr; start_limit = LW'(lim);
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      repeat (2) @(negedge clk);
      check(busy == 1'b1, "R10 busy at second start", int'(busy), 1);
      start = 1'b1; start_addr = ~addr; start_limit = '0;
      @(negedge clk);
      start = 1'b0;
    end
    wd = 0;
    while (!done && wd < 20000) begin
      @(negedge clk);
      wd++;
    end
    check(done == 1'b1, {tag, " done reached"}, int'(done), 1);
    check(ok == p_ok, {tag, " ok"}, int'(ok), int'(p_ok));
    check(int'(elapsed_ms) == p_ms, {"R9 elapsed for ", tag}, int'(elapsed_ms), p_ms);
    check((n_reads - base) == p_reads, {"R2 read count for ", tag}, n_reads - base, p_reads);
    check(addr_bad == bad0, "R2 read address", addr_bad - bad0, 0);
    @(negedge clk);
    check(done == 1'b0, "R9 done single cycle", int'(done), 0);
    check(busy == 1'b0, "R9 idle after done", int'(busy), 0);
  endtask

  initial begin
    void'($urandom(32'h5eed_0042));
    for (int i = 0; i < 64; i++) script[i] = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(busy == 1'b0 && done == 1'b0 && ok == 1'b0, "R1 outputs at reset",
          int'({busy, done, ok}), 0);
    check(rd_valid == 1'b0, "R1 no read at reset", int'(rd_valid), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R3: immediate completion
    for (int i = 0; i < 64; i++) script[i] = 16'h0000;
    run_trial(3, -1, 16'h1234, 1'b0);

    // R2: the discarded read differs in bit 6 and bit 5 but is ignored
    script[0] = 16'h0060; script[1] = 16'h0000; script[2] = 16'h0000;
    run_trial(2, -1, 16'h0AA8, 1'b0);

    // R4: the confirming pair matches
    for (int i = 0; i < 64; i++) script[i] = '0;
    script[1] = 16'h0060; script[2] = 16'h0000; script[3] = 16'h0040; script[4] = 16'h0040;
    run_trial(5, -1, 16'h0554, 1'b0);

    // R5: the confirming pair still toggles
    script[1] = 16'h0060; script[2] = 16'h0000; script[3] = 16'h0040; script[4] = 16'h0000;
    run_trial(5, -1, 16'h0554, 1'b0);

    // R6 and R7: limit 0 fails after the first tick
    fill_toggle();
    run_trial(0, -1, 16'h1550, 1'b0);
    // R7: the largest limit runs the count to one past it
    run_trial(15, -1, 16'h1550, 1'b0);
    // R6: two waited rounds, then completion
    fill_toggle();
    script[7] = 16'h0000; script[8] = 16'h0000;
    run_trial(4, -1, 16'h2000, 1'b0);

    // R8: error on the discarded read, and after one waited round
    fill_toggle();
    run_trial(4, 0, 16'h3000, 1'b0);
    run_trial(4, 4, 16'h3002, 1'b0);
    // R8: error inside the confirming pair
    for (int i = 0; i < 64; i++) script[i] = '0;
    script[1] = 16'h0060; script[2] = 16'h0000;
    run_trial(4, 3, 16'h3004, 1'b0);

    // R10: start while busy is ignored
    fill_toggle();
    script[4] = 16'h0000; script[5] = 16'h0000;
    run_trial(6, -1, 16'h4000, 1'b1);

    // random scripts, budgets and errors
    for (int t = 0; t < 40; t++) begin
      int lim, erri;
      for (int i = 0; i < 64; i++) script[i] = 16'($urandom);
      lim  = int'($urandom % 7);
      erri = (($urandom % 8) == 0) ? int'($urandom % 12) : -1;
      run_trial(lim, erri, AW'($urandom), ($urandom % 5) == 0 && erri < 0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule